// File: doc/BRIEF.md
# Accumulator Machine Step Sequencer and Control Decoder

This block is the fixed-logic control unit of a small accumulator computer that has four instructions: load, add, store and branch-when-accumulator-is-zero. It keeps a one-hot step counter with eight steps, T0 to T7. Each data-path control line is formed as a sum of products, where each product combines one step line with a decoded opcode line and, for the branch, the accumulator-zero flag.

The first four steps are the same for every instruction. T0 sends the program counter to the memory address register. T1 starts a memory read and increments the program counter. T2 moves the memory data register into the instruction register. T3 is an idle step in which the opcode is decoded. From T4 onward the decoded opcode selects the execute steps. Each instruction has a final step that sends the counter back to T0.

The instruction register's opcode field and the accumulator-zero flag come in directly from the data path. The control lines go out to the data path with no register stage.

The step counter moves through these states:
- `ST_T0` → `ST_T1` → `ST_T2` → `ST_T3` → `ST_T4` → `ST_T5`.
- `ST_T5` goes back to `ST_T0` for a branch and otherwise goes to `ST_T6`.
- `ST_T6` goes back to `ST_T0` for load and store and otherwise goes to `ST_T7`.
- `ST_T7` always goes back to `ST_T0`.

Top module: `acu_ctrl_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, the step counter is at T0 after that edge (`step_oh` = 8'b0000_0001), whatever step it was in before.
- R2: The fetch steps drive these lines for every opcode: T0 drives `pc_drive` and `mar_load`; T1 drives `mem_read` and `pc_step`; T2 drives `mdr_drive` and `ir_load`. T3 drives no control line.
- R3: During T0 to T2 the decoded opcode lines are all zero. No line that depends on the opcode can assert in those steps, whatever value `ir_op` and `acc_is_zero` hold.
- R4: Load (`ir_op` = 2'b00) drives `ir_addr_drive` and `mar_load` at T4, `mem_read` at T5, and `mdr_drive` and `acc_load` at T6. It then returns to T0, so the instruction takes 7 cycles.
- R5: Add (`ir_op` = 2'b01) drives `ir_addr_drive` and `mar_load` at T4, `mem_read` at T5, `acc_drive` and `alu_sum` at T6, and `tmp_drive` and `acc_load` at T7. It then returns to T0, so the instruction takes 8 cycles.
- R6: Store (`ir_op` = 2'b10) drives `ir_addr_drive` and `mar_load` at T4, `acc_drive` and `mdr_load` at T5, and `mem_write` at T6. It then returns to T0, so the instruction takes 7 cycles.
- R7: Branch (`ir_op` = 2'b11) with `acc_is_zero` high drives `ir_addr_drive` and `pc_load` at T4. It drives nothing at T5 and then returns to T0, so the instruction takes 6 cycles.
- R8: Branch with `acc_is_zero` low drives no control line at T4 or T5. It still returns to T0 after T5, so the instruction takes 6 cycles.
- R9: Exactly one bit of `step_oh` is set in every cycle after reset (bit k means step Tk). Unless a return-to-T0 term is active, the counter moves up by exactly one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_op | input | 2 | Opcode field of the instruction register |
| acc_is_zero | input | 1 | High when the accumulator holds zero |
| step_oh | output | 8 | One-hot time step; bit k is step Tk |
| pc_drive | output | 1 | Drive the program counter onto the internal bus |
| mar_load | output | 1 | Load the memory address register |
| mem_read | output | 1 | Start a memory read |
| pc_step | output | 1 | Increment the program counter |
| mdr_drive | output | 1 | Drive the memory data register onto the bus |
| ir_load | output | 1 | Load the instruction register |
| ir_addr_drive | output | 1 | Drive the address field of the instruction register onto the bus |
| acc_load | output | 1 | Load the accumulator |
| acc_drive | output | 1 | Drive the accumulator onto the bus |
| alu_sum | output | 1 | Select addition in the ALU |
| tmp_drive | output | 1 | Drive the ALU result register onto the bus |
| mdr_load | output | 1 | Load the memory data register |
| mem_write | output | 1 | Start a memory write |
| pc_load | output | 1 | Load the program counter from the bus |

## Verification
The control lines are combinational in the current step and the inputs, so each is due in the same cycle as the step that selects it. `step_oh` changes one clock edge after the step that caused the change. The bench changes inputs and compares outputs on the falling edge, half a period away from the rising edge that advances the counter. It walks each instruction one step per cycle and compares the full control word against an expected value built from the step index, the opcode and the zero flag. After the last step of each instruction it also checks that the counter is back at T0, which confirms the instruction length.

// File: rtl/acu_pkg.sv
package acu_pkg;

    localparam int NUM_STEPS   = 8;
    localparam int OP_W        = 2;
    localparam int DECODE_FROM = 3;
    localparam int STEP_W      = $clog2(NUM_STEPS);

    typedef enum logic [STEP_W-1:0] {
        ST_T0 = 3'd0,
        ST_T1 = 3'd1,
        ST_T2 = 3'd2,
        ST_T3 = 3'd3,
        ST_T4 = 3'd4,
        ST_T5 = 3'd5,
        ST_T6 = 3'd6,
        ST_T7 = 3'd7
    } step_e;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 2'b00,
        OP_ADD   = 2'b01,
        OP_STORE = 2'b10,
        OP_BRZ   = 2'b11
    } op_e;

    typedef struct packed {
        logic ld;
        logic ad;
        logic st;
        logic bz;
    } op_lines_t;

endpackage

// File: rtl/acu_step_seq.sv
module acu_step_seq
    import acu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart,
    output logic [NUM_STEPS-1:0] step_oh
);

    step_e step_q;
    step_e step_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_T0;
        end else begin
            step_q <= step_d;
        end
    end

    // Next step: advance by one unless the current instruction ends here
    always_comb begin
        step_d = ST_T0;
        unique case (step_q)
            ST_T0: step_d = restart ? ST_T0 : ST_T1;
            ST_T1: step_d = restart ? ST_T0 : ST_T2;
            ST_T2: step_d = restart ? ST_T0 : ST_T3;
            ST_T3: step_d = restart ? ST_T0 : ST_T4;
            ST_T4: step_d = restart ? ST_T0 : ST_T5;
            ST_T5: step_d = restart ? ST_T0 : ST_T6;
            ST_T6: step_d = restart ? ST_T0 : ST_T7;
            ST_T7: step_d = ST_T0;
            default: step_d = ST_T0;
        endcase
    end

    // One-hot expansion of the step state
    for (genvar k = 0; k < NUM_STEPS; k++) begin : g_oh
        assign step_oh[k] = (step_q == step_e'(k));
    end

    p_reset_to_t0_r1: assert property (@(posedge clk)
        rst |=> (step_oh == {{(NUM_STEPS-1){1'b0}}, 1'b1}));

    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $countones(step_oh) == 1);

    p_advance_r9: assert property (@(posedge clk) disable iff (rst)
        !restart |=> (step_oh == ($past(step_oh) << 1)));

endmodule

// File: rtl/acu_op_decode.sv
module acu_op_decode
    import acu_pkg::*;
(
    input  logic [OP_W-1:0]      ir_op,
    input  logic [NUM_STEPS-1:0] step_oh,
    output op_lines_t            ops
);

    logic decode_en;

    // Opcode lines are only live once the instruction register is stable
    assign decode_en = ~|step_oh[DECODE_FROM-1:0] & |step_oh[NUM_STEPS-1:DECODE_FROM];

    always_comb begin
        ops = '0;
        if (decode_en) begin
            unique case (op_e'(ir_op))
                OP_LOAD:  ops.ld = 1'b1;
                OP_ADD:   ops.ad = 1'b1;
                OP_STORE: ops.st = 1'b1;
                OP_BRZ:   ops.bz = 1'b1;
                default:  ops = '0;
            endcase
        end
    end

endmodule

// File: rtl/acu_ctrl_terms.sv
module acu_ctrl_terms
    import acu_pkg::*;
(
    input  logic [NUM_STEPS-1:0] step_oh,
    input  op_lines_t            ops,
    input  logic                 acc_is_zero,
    output logic                 restart,
    output logic                 pc_drive,
    output logic                 mar_load,
    output logic                 mem_read,
    output logic                 pc_step,
    output logic                 mdr_drive,
    output logic                 ir_load,
    output logic                 ir_addr_drive,
    output logic                 acc_load,
    output logic                 acc_drive,
    output logic                 alu_sum,
    output logic                 tmp_drive,
    output logic                 mdr_load,
    output logic                 mem_write,
    output logic                 pc_load
);

    logic t0, t1, t2, t4, t5, t6, t7;
    logic mem_op;
    logic taken;

    assign t0 = step_oh[0];
    assign t1 = step_oh[1];
    assign t2 = step_oh[2];
    assign t4 = step_oh[4];
    assign t5 = step_oh[5];
    assign t6 = step_oh[6];
    assign t7 = step_oh[7];

    assign mem_op = ops.ld | ops.ad | ops.st;
    assign taken  = ops.bz & acc_is_zero;

    // Sum-of-products control terms
    always_comb begin
        pc_drive      = t0;
        mar_load      = t0 | (mem_op & t4);
        mem_read      = t1 | ((ops.ld | ops.ad) & t5);
        pc_step       = t1;
        mdr_drive     = t2 | (ops.ld & t6);
        ir_load       = t2;
        ir_addr_drive = (mem_op & t4) | (taken & t4);
        acc_load      = (ops.ld & t6) | (ops.ad & t7);
        acc_drive     = (ops.st & t5) | (ops.ad & t6);
        alu_sum       = ops.ad & t6;
        tmp_drive     = ops.ad & t7;
        mdr_load      = ops.st & t5;
        mem_write     = ops.st & t6;
        pc_load       = taken & t4;
        restart       = (ops.ld & t6) | (ops.st & t6) | (ops.ad & t7) | (ops.bz & t5) | t7;
    end

    // R7: a program counter load only ever comes with a zero accumulator
    always_comb begin
        if (pc_load) begin
            a_branch_cond_r7: assert (acc_is_zero && ir_addr_drive);
        end
    end

endmodule

// File: rtl/acu_ctrl_unit.sv
module acu_ctrl_unit
    import acu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OP_W-1:0]      ir_op,
    input  logic                 acc_is_zero,
    output logic [NUM_STEPS-1:0] step_oh,
    output logic                 pc_drive,
    output logic                 mar_load,
    output logic                 mem_read,
    output logic                 pc_step,
    output logic                 mdr_drive,
    output logic                 ir_load,
    output logic                 ir_addr_drive,
    output logic                 acc_load,
    output logic                 acc_drive,
    output logic                 alu_sum,
    output logic                 tmp_drive,
    output logic                 mdr_load,
    output logic                 mem_write,
    output logic                 pc_load
);

    logic      restart;
    op_lines_t ops;

    acu_step_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .step_oh (step_oh)
    );

    acu_op_decode u_dec (
        .ir_op   (ir_op),
        .step_oh (step_oh),
        .ops     (ops)
    );

    acu_ctrl_terms u_terms (
        .step_oh       (step_oh),
        .ops           (ops),
        .acc_is_zero   (acc_is_zero),
        .restart       (restart),
        .pc_drive      (pc_drive),
        .mar_load      (mar_load),
        .mem_read      (mem_read),
        .pc_step       (pc_step),
        .mdr_drive     (mdr_drive),
        .ir_load       (ir_load),
        .ir_addr_drive (ir_addr_drive),
        .acc_load      (acc_load),
        .acc_drive     (acc_drive),
        .alu_sum       (alu_sum),
        .tmp_drive     (tmp_drive),
        .mdr_load      (mdr_load),
        .mem_write     (mem_write),
        .pc_load       (pc_load)
    );

    p_fetch_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (|step_oh[DECODE_FROM-1:0]) |->
            !(ir_addr_drive | acc_load | acc_drive | alu_sum | tmp_drive | mdr_load | mem_write | pc_load));

    p_load_end_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_load && mdr_drive) |=> step_oh[0]);

    p_add_tail_r5: assert property (@(posedge clk) disable iff (rst)
        alu_sum |=> (tmp_drive && acc_load));

    p_store_end_r6: assert property (@(posedge clk) disable iff (rst)
        mem_write |=> step_oh[0]);

    p_decode_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> !(pc_drive | mar_load | mem_read | pc_step | mdr_drive | ir_load | ir_addr_drive
                     | acc_load | acc_drive | alu_sum | tmp_drive | mdr_load | mem_write | pc_load));

endmodule

// File: tb/acu_ctrl_unit_tb.sv
module acu_ctrl_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;

    // Control word bit positions (bench-side packing)
    localparam int B_PCD = 13, B_MARL = 12, B_RD = 11, B_PCS = 10, B_MDRD = 9, B_IRL = 8, B_IRA = 7;
    localparam int B_ACCL = 6, B_ACCD = 5, B_SUM = 4, B_TMP = 3, B_MDRL = 2, B_WR = 1, B_PCL = 0;

    // Vector: {early_op[1:0], op[1:0], acc_zero, length[3:0]}
    localparam logic [8:0] VEC [NVEC] = '{
        {2'b00, 2'b00, 1'b0, 4'd7},
        {2'b01, 2'b01, 1'b1, 4'd8},
        {2'b10, 2'b10, 1'b0, 4'd7},
        {2'b11, 2'b11, 1'b1, 4'd6},
        {2'b11, 2'b11, 1'b0, 4'd6},
        {2'b11, 2'b00, 1'b1, 4'd7},
        {2'b01, 2'b10, 1'b1, 4'd7},
        {2'b10, 2'b01, 1'b0, 4'd8}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ir_op = 2'b00;
    logic       acc_is_zero = 1'b0;
    logic [7:0] step_oh;
    logic pc_drive, mar_load, mem_read, pc_step, mdr_drive, ir_load, ir_addr_drive;
    logic acc_load, acc_drive, alu_sum, tmp_drive, mdr_load, mem_write, pc_load;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acu_ctrl_unit u_dut (
        .clk(clk), .rst(rst), .ir_op(ir_op), .acc_is_zero(acc_is_zero), .step_oh(step_oh),
        .pc_drive(pc_drive), .mar_load(mar_load), .mem_read(mem_read), .pc_step(pc_step),
        .mdr_drive(mdr_drive), .ir_load(ir_load), .ir_addr_drive(ir_addr_drive),
        .acc_load(acc_load), .acc_drive(acc_drive), .alu_sum(alu_sum), .tmp_drive(tmp_drive),
        .mdr_load(mdr_load), .mem_write(mem_write), .pc_load(pc_load)
    );

    function automatic logic [13:0] ctrl_now();
        return {pc_drive, mar_load, mem_read, pc_step, mdr_drive, ir_load, ir_addr_drive,
                acc_load, acc_drive, alu_sum, tmp_drive, mdr_load, mem_write, pc_load};
    endfunction

    // Expected control word from the requirement text
    function automatic logic [13:0] exp_ctrl(int s, logic [1:0] op, logic z);
        logic [13:0] w = '0;
        case (s)
            0: begin w[B_PCD] = 1; w[B_MARL] = 1; end
            1: begin w[B_RD] = 1; w[B_PCS] = 1; end
            2: begin w[B_MDRD] = 1; w[B_IRL] = 1; end
            4: begin
                if (op != 2'b11) begin w[B_IRA] = 1; w[B_MARL] = 1; end
                else if (z)     begin w[B_IRA] = 1; w[B_PCL] = 1; end
            end
            5: begin
                if (op == 2'b00 || op == 2'b01) w[B_RD] = 1;
                else if (op == 2'b10) begin w[B_ACCD] = 1; w[B_MDRL] = 1; end
            end
            6: begin
                if (op == 2'b00)      begin w[B_MDRD] = 1; w[B_ACCL] = 1; end
                else if (op == 2'b01) begin w[B_ACCD] = 1; w[B_SUM] = 1; end
                else if (op == 2'b10) w[B_WR] = 1;
            end
            7: if (op == 2'b01) begin w[B_TMP] = 1; w[B_ACCL] = 1; end
            default: ;
        endcase
        return w;
    endfunction

    function automatic string req_of(int s, logic [1:0] op, logic z);
        if (s < 3) return "R2/R3";
        if (s == 3) return "R2";
        case (op)
            2'b00: return "R4";
            2'b01: return "R5";
            2'b10: return "R6";
            default: return z ? "R7" : "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(step_oh == 8'h01, "R1", {8'h0, step_oh}, 16'h0001);
        check(ctrl_now() == exp_ctrl(0, 2'b00, 1'b0), "R1", {2'b0, ctrl_now()}, {2'b0, exp_ctrl(0, 2'b00, 1'b0)});

        // Table walk: each vector is one whole instruction
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] early_op, op;
            logic       z;
            int         len;
            early_op = VEC[v][8:7];
            op       = VEC[v][6:5];
            z        = VEC[v][4];
            len      = int'(VEC[v][3:0]);
            for (int s = 0; s < len; s++) begin
                ir_op       = (s < 3) ? early_op : op;
                acc_is_zero = (s < 3) ? ~z : z;
                #1;
                check(step_oh == (8'h01 << s), "R9", {8'h0, step_oh}, {8'h0, 8'h01 << s});
                check(ctrl_now() == exp_ctrl(s, op, z), req_of(s, op, z),
                      {2'b0, ctrl_now()}, {2'b0, exp_ctrl(s, op, z)});
                @(negedge clk);
            end
            // Instruction length: back at T0 after the last step
            check(step_oh == 8'h01, req_of(4, op, z), {8'h0, step_oh}, 16'h0001);
        end

        // R1: reset in the middle of an add, at T5
        ir_op = 2'b01;
        acc_is_zero = 1'b0;
        repeat (5) @(negedge clk);
        check(step_oh == 8'h20, "R9", {8'h0, step_oh}, 16'h0020);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(step_oh == 8'h01, "R1", {8'h0, step_oh}, 16'h0001);

        // R3: fetch steps with branch-taken inputs show only fetch lines
        ir_op = 2'b11;
        acc_is_zero = 1'b1;
        for (int s = 0; s < 3; s++) begin
            #1;
            check(ctrl_now() == exp_ctrl(s, 2'b11, 1'b1), "R3",
                  {2'b0, ctrl_now()}, {2'b0, exp_ctrl(s, 2'b11, 1'b1)});
            @(negedge clk);
        end

        finish_run();
    end

endmodule